// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block is a hardware state machine that takes a PCIe root port from reset to a state in which configuration requests may be issued. After a start pulse it selects root-complex mode, releases the powerdown and soft-reset lines in a fixed order, and waits a settle interval so the controller can initialise. It then asks the PHY to initialise and waits for the PHY to report done. Next it pulses the fundamental-reset line to the endpoint, enables link training and waits for link-up. When the fundamental-reset pulse is fitted, the block also waits a long post-link interval before it raises config-ready.

Every delay is a parameter counted in clock cycles. The fundamental-reset pulse and the powerdown release are each selected by a parameter. If link-up does not arrive within a timeout, the block parks in an error state. Only a new start pulse leaves that state. A start pulse in any state restarts the sequence at its first step. The current step is visible on a state output.

Top module: `pcie_rp_bringup_seq`

## Requirements
- R1: After reset the state output reads 0 (idle) and stays there until a start pulse. In idle, rc_mode_o, pwrdn_rel_o, srst_rel_o, phy_init_o, ltssm_en_o, cfg_ready_o and err_o are 0 and perst_n_o is 1.
- R2: A start_i sampled high in any state makes the state output read 1 in the next cycle. In that cycle rc_mode_o is 1, both reset releases are 0 and ltssm_en_o is 0.
- R3: With HAS_PWRDN=1, the powerdown release (state 2) lasts exactly one cycle and comes before the soft-reset release (state 3, one cycle). Both release outputs then stay high. With HAS_PWRDN=0, state 2 never occurs and pwrdn_rel_o stays 0.
- R4: After the soft-reset release, the settle step (state 4) lasts exactly SETTLE_CYC cycles before PHY init begins.
- R5: phy_init_o is high only in state 5. The block stays in state 5 until phy_done_i is sampled high, so state 5 lasts d+1 cycles when done arrives d cycles after entry. ltssm_en_o is 0 in every state below 7.
- R6: With HAS_PERST=1, perst_n_o is low for exactly PERST_CYC cycles (state 6) right after PHY done, and the LTSSM enable rises only after that. With HAS_PERST=0, state 6 is skipped and perst_n_o stays 1.
- R7: ltssm_en_o is high in states 7, 8 and 9. When link_up_i is sampled high in state 7 and HAS_PERST=1, the post-link wait (state 8) lasts exactly POST_CYC cycles. After it comes state 9 with cfg_ready_o=1. With HAS_PERST=0 the block goes from state 7 straight to state 9.
- R8: If link_up_i stays low for LINK_TMO_CYC cycles in state 7, the block enters state 10 with err_o=1 and ltssm_en_o=0. A link-up sampled in the last of those cycles still counts as success.
- R9: State 10 is left only through start_i. phy_done_i and link_up_i have no effect there. State 9 is likewise held until start_i.
- R10: State codes on state_o: 0 idle, 1 root-complex select, 2 powerdown release, 3 soft-reset release, 4 settle, 5 PHY init, 6 fundamental reset, 7 link training, 8 post-link wait, 9 ready, 10 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or restart the sequence |
| phy_done_i | input | 1 | PHY reports initialisation done |
| link_up_i | input | 1 | Link reports up |
| rc_mode_o | output | 1 | Device-type select, 1 = root complex |
| pwrdn_rel_o | output | 1 | Powerdown released |
| srst_rel_o | output | 1 | Soft reset released |
| phy_init_o | output | 1 | PHY initialisation request |
| perst_n_o | output | 1 | Fundamental reset to the endpoint, active low |
| ltssm_en_o | output | 1 | Link training enable |
| cfg_ready_o | output | 1 | Configuration traffic allowed |
| err_o | output | 1 | Link-up timeout occurred |
| state_o | output | 4 | Current step code |

## Verification
A wrong state shows up at once on state_o. It also shows up on the decoded control outputs in the same cycle. A stray LTSSM enable before PHY done, or a reset release out of order, is therefore visible in a single cycle. A wrong interval length is the other failure mode. It moves every later transition, so measuring the cycles spent in each step exposes an off-by-one in the settle, reset-pulse, post-link or timeout count. This is seen as soon as that step ends. The trimmed variant is run beside the full one to show that the skipped steps never appear.

// File: rtl/pcie_bringup_pkg.sv
package pcie_bringup_pkg;
   localparam int ST_W = 4;
   typedef enum logic [ST_W-1:0] {
      ST_IDLE       = 4'd0,
      ST_SET_RC     = 4'd1,
      ST_PWR_REL    = 4'd2,
      ST_SRST_REL   = 4'd3,
      ST_SETTLE     = 4'd4,
      ST_PHY_INIT   = 4'd5,
      ST_PERST_ON   = 4'd6,
      ST_LINK_TRAIN = 4'd7,
      ST_POST_WAIT  = 4'd8,
      ST_READY      = 4'd9,
      ST_ERROR      = 4'd10
   } seq_state_e;
endpackage

// File: rtl/bringup_timer.sv
// Cycles-in-state counter: cleared on each state change, saturates at all ones.
module bringup_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_o <= '0;
      else if (clr_i)          cnt_o <= '0;
      else if (cnt_o != '1)    cnt_o <= cnt_o + CNT_W'(1);
   end
endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
   import pcie_bringup_pkg::*;
#(
   parameter bit HAS_PWRDN  = 1'b1,
   parameter bit HAS_PERST  = 1'b1,
   parameter int CNT_W      = 8,
   parameter int SETTLE_CYC = 4,
   parameter int PERST_CYC  = 4,
   parameter int POST_CYC   = 4,
   parameter int TMO_CYC    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             phy_done_i,
   input  logic             link_up_i,
   input  logic [CNT_W-1:0] cnt_i,
   output seq_state_e       state_o,
   output logic             tmr_clr_o
);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] PERST_LAST  = CNT_W'(PERST_CYC - 1);
   localparam logic [CNT_W-1:0] POST_LAST   = CNT_W'(POST_CYC - 1);
   localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TMO_CYC - 1);

   seq_state_e state_n;

   always_comb begin
      state_n = state_o;
      unique case (state_o)
         ST_IDLE:       state_n = ST_IDLE;
         ST_SET_RC:     state_n = HAS_PWRDN ? ST_PWR_REL : ST_SRST_REL;
         ST_PWR_REL:    state_n = ST_SRST_REL;
         ST_SRST_REL:   state_n = ST_SETTLE;
         ST_SETTLE:     if (cnt_i == SETTLE_LAST) state_n = ST_PHY_INIT;
         ST_PHY_INIT:   if (phy_done_i) state_n = HAS_PERST ? ST_PERST_ON : ST_LINK_TRAIN;
         ST_PERST_ON:   if (cnt_i == PERST_LAST) state_n = ST_LINK_TRAIN;
         ST_LINK_TRAIN: begin
            if (link_up_i)               state_n = HAS_PERST ? ST_POST_WAIT : ST_READY;
            else if (cnt_i == TMO_LAST)  state_n = ST_ERROR;
         end
         ST_POST_WAIT:  if (cnt_i == POST_LAST) state_n = ST_READY;
         ST_READY:      state_n = ST_READY;
         ST_ERROR:      state_n = ST_ERROR;
         default:       state_n = ST_IDLE;
      endcase
      if (start_i) state_n = ST_SET_RC;
   end

   assign tmr_clr_o = (state_n != state_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= state_n;
   end
endmodule

// File: rtl/bringup_outdec.sv
module bringup_outdec
   import pcie_bringup_pkg::*;
#(
   parameter bit HAS_PWRDN = 1'b1,
   parameter bit HAS_PERST = 1'b1
) (
   input  seq_state_e state_i,
   output logic       rc_mode_o,
   output logic       pwrdn_rel_o,
   output logic       srst_rel_o,
   output logic       phy_init_o,
   output logic       perst_n_o,
   output logic       ltssm_en_o,
   output logic       cfg_ready_o,
   output logic       err_o
);
   logic [ST_W-1:0] s;
   assign s = state_i;

   assign rc_mode_o   = (s != ST_IDLE);
   assign srst_rel_o  = (s >= ST_SRST_REL);
   assign phy_init_o  = (s == ST_PHY_INIT);
   assign ltssm_en_o  = (s == ST_LINK_TRAIN) || (s == ST_POST_WAIT) || (s == ST_READY);
   assign cfg_ready_o = (s == ST_READY);
   assign err_o       = (s == ST_ERROR);

   generate
      if (HAS_PWRDN) begin : g_pwrdn
         assign pwrdn_rel_o = (s >= ST_PWR_REL);
      end else begin : g_no_pwrdn
         assign pwrdn_rel_o = 1'b0;
      end
      if (HAS_PERST) begin : g_perst
         assign perst_n_o = (s != ST_PERST_ON);
      end else begin : g_no_perst
         assign perst_n_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pcie_rp_bringup_seq.sv
module pcie_rp_bringup_seq
   import pcie_bringup_pkg::*;
#(
   parameter bit HAS_PWRDN  = 1'b1,
   parameter bit HAS_PERST  = 1'b1,
   parameter int SETTLE_CYC = 150000,
   parameter int PERST_CYC  = 12000,
   parameter int POST_CYC   = 10000000,
   parameter int TMO_CYC    = 2000000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            phy_done_i,
   input  logic            link_up_i,
   output logic            rc_mode_o,
   output logic            pwrdn_rel_o,
   output logic            srst_rel_o,
   output logic            phy_init_o,
   output logic            perst_n_o,
   output logic            ltssm_en_o,
   output logic            cfg_ready_o,
   output logic            err_o,
   output logic [ST_W-1:0] state_o
);
   localparam int MAX_A   = (SETTLE_CYC > PERST_CYC) ? SETTLE_CYC : PERST_CYC;
   localparam int MAX_B   = (POST_CYC > TMO_CYC) ? POST_CYC : TMO_CYC;
   localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (SETTLE_CYC < 1 || PERST_CYC < 1 || POST_CYC < 1 || TMO_CYC < 1) begin : g_bad_delay
         $error("pcie_rp_bringup_seq: every delay must be at least one cycle");
      end
   endgenerate

   seq_state_e       state_q;
   logic             tmr_clr;
   logic [CNT_W-1:0] tmr_cnt;

   bringup_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (tmr_clr),
      .cnt_o (tmr_cnt)
   );

   bringup_fsm #(
      .HAS_PWRDN  (HAS_PWRDN),
      .HAS_PERST  (HAS_PERST),
      .CNT_W      (CNT_W),
      .SETTLE_CYC (SETTLE_CYC),
      .PERST_CYC  (PERST_CYC),
      .POST_CYC   (POST_CYC),
      .TMO_CYC    (TMO_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .phy_done_i (phy_done_i),
      .link_up_i  (link_up_i),
      .cnt_i      (tmr_cnt),
      .state_o    (state_q),
      .tmr_clr_o  (tmr_clr)
   );

   bringup_outdec #(.HAS_PWRDN(HAS_PWRDN), .HAS_PERST(HAS_PERST)) u_dec (
      .state_i     (state_q),
      .rc_mode_o   (rc_mode_o),
      .pwrdn_rel_o (pwrdn_rel_o),
      .srst_rel_o  (srst_rel_o),
      .phy_init_o  (phy_init_o),
      .perst_n_o   (perst_n_o),
      .ltssm_en_o  (ltssm_en_o),
      .cfg_ready_o (cfg_ready_o),
      .err_o       (err_o)
   );

   assign state_o = state_q;
endmodule

// File: rtl/pcie_rp_bringup_seq_chk.sv
module pcie_rp_bringup_seq_chk #(
   parameter bit HAS_PWRDN = 1'b1,
   parameter bit HAS_PERST = 1'b1,
   parameter int PERST_CYC = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       phy_done_i,
   input logic       link_up_i,
   input logic       pwrdn_rel_o,
   input logic       srst_rel_o,
   input logic       phy_init_o,
   input logic       perst_n_o,
   input logic       ltssm_en_o,
   input logic       cfg_ready_o,
   input logic       err_o,
   input logic [3:0] state_o
);
   int perst_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          perst_lo_cnt <= 0;
      else if (!perst_n_o) perst_lo_cnt <= perst_lo_cnt + 1;
      else                 perst_lo_cnt <= 0;
   end

   AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (state_o == 4'd1) && !srst_rel_o && !ltssm_en_o); // R2
   AST_PWR_BEFORE_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst_rel_o) |-> (!HAS_PWRDN || $past(pwrdn_rel_o))); // R3
   AST_PHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_init_o && !phy_done_i && !start_i) |=> phy_init_o); // R5
   AST_LTSSM_AFTER_PERST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ltssm_en_o) |-> ($past(state_o) == (HAS_PERST ? 4'd6 : 4'd5))); // R6
   AST_PERST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(perst_n_o) && !$past(start_i)) |-> (perst_lo_cnt == PERST_CYC)); // R6
   AST_READY_WITH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_ready_o) |-> ltssm_en_o); // R7
   AST_ERR_FROM_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> ($past(state_o) == 4'd7) && !ltssm_en_o); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o); // R9
endmodule

bind pcie_rp_bringup_seq pcie_rp_bringup_seq_chk #(
   .HAS_PWRDN (HAS_PWRDN),
   .HAS_PERST (HAS_PERST),
   .PERST_CYC (PERST_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .phy_done_i  (phy_done_i),
   .link_up_i   (link_up_i),
   .pwrdn_rel_o (pwrdn_rel_o),
   .srst_rel_o  (srst_rel_o),
   .phy_init_o  (phy_init_o),
   .perst_n_o   (perst_n_o),
   .ltssm_en_o  (ltssm_en_o),
   .cfg_ready_o (cfg_ready_o),
   .err_o       (err_o),
   .state_o     (state_o)
);

// File: tb/pcie_rp_bringup_seq_tb.sv
`timescale 1ns/1ps
module pcie_rp_bringup_seq_tb;
   localparam int S = 20;
   localparam int P = 10;
   localparam int W = 30;
   localparam int T = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic phy_done_a = 1'b0, link_up_a = 1'b0;
   logic phy_done_b = 1'b0, link_up_b = 1'b0;

   logic rc_a, pwr_a, srst_a, phy_a, perst_a, ltssm_a, rdy_a, err_a;
   logic rc_b, pwr_b, srst_b, phy_b, perst_b, ltssm_b, rdy_b, err_b;
   logic [3:0] st_a, st_b;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   pcie_rp_bringup_seq #(.HAS_PWRDN(1'b1), .HAS_PERST(1'b1), .SETTLE_CYC(S),
      .PERST_CYC(P), .POST_CYC(W), .TMO_CYC(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .phy_done_i(phy_done_a),
      .link_up_i(link_up_a), .rc_mode_o(rc_a), .pwrdn_rel_o(pwr_a),
      .srst_rel_o(srst_a), .phy_init_o(phy_a), .perst_n_o(perst_a),
      .ltssm_en_o(ltssm_a), .cfg_ready_o(rdy_a), .err_o(err_a), .state_o(st_a));

   pcie_rp_bringup_seq #(.HAS_PWRDN(1'b0), .HAS_PERST(1'b0), .SETTLE_CYC(S),
      .PERST_CYC(P), .POST_CYC(W), .TMO_CYC(T)) u_dut_min (
      .clk(clk), .rst_n(rst_n), .start_i(start), .phy_done_i(phy_done_b),
      .link_up_i(link_up_b), .rc_mode_o(rc_b), .pwrdn_rel_o(pwr_b),
      .srst_rel_o(srst_b), .phy_init_o(phy_b), .perst_n_o(perst_b),
      .ltssm_en_o(ltssm_b), .cfg_ready_o(rdy_b), .err_o(err_b), .state_o(st_b));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      vectors = vectors + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_train(input int ld);
      return (ld < T) ? ld + 1 : T;
   endfunction

   function automatic int exp_term(input int ld);
      return (ld < T) ? 9 : 10;
   endfunction

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   // Runs a full sequence on both instances; pd = PHY-done delay, ld = link-up delay.
   task automatic run_pair(input int pd, input int ld);
      int ca[16];
      int cb[16];
      int ps_a = 0, ps_b = 0, ls_a = 0, ls_b = 0;
      int v_order = 0, v_min = 0, v_rel = 0, v_err = 0;
      for (int i = 0; i < 16; i++) begin ca[i] = 0; cb[i] = 0; end
      pulse_start();
      for (int k = 0; k < 2000; k++) begin
         ca[st_a] = ca[st_a] + 1;
         cb[st_b] = cb[st_b] + 1;
         if ((ltssm_a && st_a < 4'd7) || (ltssm_b && st_b < 4'd7)) v_order++;
         if (!perst_b || pwr_b) v_min++;
         if ((st_a == 4'd1 && (srst_a || pwr_a)) || (st_a == 4'd2 && srst_a)) v_rel++;
         if ((st_a == 4'd10 && ltssm_a) || (st_b == 4'd10 && ltssm_b)) v_err++;
         if ((st_a >= 4'd9) && (st_b >= 4'd9)) break;
         phy_done_a = phy_a && (ps_a >= pd);
         phy_done_b = phy_b && (ps_b >= pd);
         if (phy_a) ps_a++;
         if (phy_b) ps_b++;
         link_up_a = (st_a == 4'd7) && (ls_a >= ld);
         link_up_b = (st_b == 4'd7) && (ls_b >= ld);
         if (st_a == 4'd7) ls_a++;
         if (st_b == 4'd7) ls_b++;
         @(negedge clk);
      end
      phy_done_a = 1'b0; phy_done_b = 1'b0; link_up_a = 1'b0; link_up_b = 1'b0;
      chk("R2 root-complex select step full", ca[1], 1);
      chk("R3 powerdown release step full", ca[2], 1);
      chk("R3 soft-reset release step full", ca[3], 1);
      chk("R3 powerdown step absent in trimmed", cb[2], 0);
      chk("R3 release ordering", v_rel, 0);
      chk("R4 settle length full", ca[4], S);
      chk("R4 settle length trimmed", cb[4], S);
      chk("R5 PHY init length full", ca[5], pd + 1);
      chk("R5 PHY init length trimmed", cb[5], pd + 1);
      chk("R5 LTSSM enable held low before training", v_order, 0);
      chk("R6 fundamental reset width", ca[6], P);
      chk("R6 trimmed skips reset pulse and powerdown", cb[6] + v_min, 0);
      chk("R8 training length full", ca[7], exp_train(ld));
      chk("R8 training length trimmed", cb[7], exp_train(ld));
      chk("R7 post-link wait full", ca[8], (ld < T) ? W : 0);
      chk("R7 no post-link wait trimmed", cb[8], 0);
      chk("R10 final state full", st_a, exp_term(ld));
      chk("R10 final state trimmed", st_b, exp_term(ld));
      chk("R7 cfg ready full", rdy_a, (ld < T) ? 1 : 0);
      chk("R8 err flag full", err_a, (ld < T) ? 0 : 1);
      chk("R8 LTSSM off in error", v_err, 0);
   endtask

   initial begin
      void'($urandom(32'h0bad5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: idle after reset, no start
      chk("R1 idle state", st_a, 0);
      chk("R1 idle state trimmed", st_b, 0);
      chk("R1 controls low", int'({rc_a, pwr_a, srst_a, phy_a, ltssm_a, rdy_a, err_a}), 0);
      chk("R1 perst high", perst_a, 1);

      // Directed corner cases
      run_pair(0, 0);
      run_pair(3, T - 1);   // link-up on the last allowed cycle: success (R8)
      run_pair(2, T);       // timeout (R8)

      // R9: error state ignores PHY-done and link-up
      phy_done_a = 1'b1; link_up_a = 1'b1;
      repeat (12) @(negedge clk);
      chk("R9 error sticky state", st_a, 10);
      chk("R9 error sticky flag", err_a, 1);
      phy_done_a = 1'b0; link_up_a = 1'b0;

      // R2: restart in the middle of settle
      pulse_start();
      repeat (6) @(negedge clk);
      chk("R4 in settle before restart", st_a, 4);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R2 restart state", st_a, 1);
      chk("R2 restart releases low", int'({srst_a, pwr_a}), 0);
      chk("R2 restart rc mode", rc_a, 1);

      run_pair(1, 5);
      repeat (8) @(negedge clk);
      chk("R9 ready held", st_a, 9);

      // Random runs
      for (int n = 0; n < 14; n++) begin
         int pd;
         int ld;
         pd = int'($urandom % 8);
         ld = int'($urandom % (T + 12));
         run_pair(pd, ld);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule